// File: doc/BRIEF.md
# Sliding-Window Serial Pattern Detector

This block watches a one-bit serial stream and raises a flag whenever the four most recent bits, taken in arrival order, form the pattern 1, 0, 1, 0. It keeps those bits in a four-stage shift register. Each clock pushes the new bit in at the low end and drops the oldest bit off the high end. The flag is decoded from the register contents alone, so it is a Moore output: it changes only after clock edges, never because the serial input moves between edges.

Because the window moves by one bit per clock, detections may overlap. The tail "10" of one hit can serve as the head of the next, so the stream 1,0,1,0,1,0 gives two hits. Reset is synchronous and active low. It loads the window with all ones, a value that does not match the pattern.

A build-time option adds a fill qualifier. When it is enabled, the flag stays low until four bits have been shifted in since reset, so a hit can never lean on preset bits. When it is disabled, the preset bits take part in the comparison like any other bits.

Top module: `pattern_window_detector`

## Requirements
- R1: While `rst_n_i` is low, `match_o` is 0.
- R2: A rising clock edge with `rst_n_i` low loads `win_o` with the preset 4'b1111.
- R3: Each rising edge with `rst_n_i` high moves `win_o[i-1]` into `win_o[i]`, places `din_i` in `win_o[0]` (newest bit), and discards the old `win_o[3]` (oldest bit).
- R4: With the fill qualifier disabled and `rst_n_i` high, `match_o` is 1 exactly when `win_o` equals 4'b1010, i.e. the bits 1, 0, 1, 0 arrived in that order with the final 0 newest.
- R5: `match_o` depends only on registered state. Changing `din_i` between clock edges leaves it unchanged.
- R6: Hits may overlap. The stream 1,0,1,0,1,0 after reset yields two hits, and 1,0,1,0,1,0,1,0 yields three. Two hits are never on adjacent cycles.
- R7: With the fill qualifier enabled, `match_o` stays 0 until at least four bits have been shifted in since reset. With it disabled, the sequence 0,1,0 right after reset gives a hit because the preset supplies the leading 1.
- R8: `match_o` rises in the cycle that begins with the clock edge on which the final 0 of the pattern is shifted in, and it falls after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_n_i | input | 1 | Synchronous reset, active low |
| din_i | input | 1 | Serial data bit, sampled on each rising edge |
| win_o | output | 4 | Current window; bit 0 is the newest bit |
| match_o | output | 1 | High while the window holds the pattern (Moore) |

## Verification
After each reset, every 8-bit input sequence is fed in. This covers hits at every possible position, hits that lean on preset bits, and windows that differ from the pattern in exactly one bit. The same sweep runs against a second instance built with the fill qualifier, which separates a true four-bit hit from one completed by the preset. Directed streams of alternating bits count overlapping hits, and a long pseudo-random stream checks that the window never loses a bit. In every cycle the serial input is flipped after the edge, to show that the flag ignores it.

// File: rtl/pwd_pkg.sv
// Package: shared defaults and helpers for the sliding-window pattern detector.
// Assumes: the window is at least two bits wide.
package pwd_pkg;
    localparam int unsigned PWD_WIDTH   = 4;
    localparam logic [3:0]  PWD_PATTERN = 4'b1010;
    localparam logic [3:0]  PWD_PRESET  = 4'b1111;

    // Width of a counter that must reach the value n inclusive.
    function automatic int unsigned pwd_count_bits(input int unsigned n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/pwd_shift_window.sv
// Module: pwd_shift_window
// Holds the last WIDTH serial bits. The newest bit enters at bit 0 and the
// oldest leaves from bit WIDTH-1. Synchronous active-low reset loads PRESET.
// Assumes: WIDTH >= 2.
module pwd_shift_window #(
    parameter int unsigned       WIDTH  = 4,
    parameter logic [WIDTH-1:0] PRESET = '1
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             din_i,
    output logic [WIDTH-1:0] win_o
);
    // Shift one bit per clock, or reload the preset during reset.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            win_o <= PRESET;
        end else begin
            win_o <= {win_o[WIDTH-2:0], din_i};
        end
    end
endmodule

// File: rtl/pwd_fill_tracker.sv
// Module: pwd_fill_tracker
// Counts the bits shifted in since reset and saturates at DEPTH. filled_o
// goes high once the window holds only bits received after reset.
// Assumes: DEPTH >= 1.
module pwd_fill_tracker #(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk_i,
    input  logic rst_n_i,
    output logic filled_o
);
    localparam int unsigned   CW    = pwd_pkg::pwd_count_bits(DEPTH);
    localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

    logic [CW-1:0] count_q;

    // Saturating count of the bits accepted since the last reset.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            count_q <= '0;
        end else if (count_q != LIMIT) begin
            count_q <= count_q + CW'(1);
        end
    end

    assign filled_o = (count_q == LIMIT);
endmodule

// File: rtl/pwd_match_decode.sv
// Module: pwd_match_decode
// Compares the registered window with PATTERN bit by bit. The hit is
// qualified by the reset level and by an external fill qualifier.
// Assumes: win_i comes straight from flops, so the output is Moore.
module pwd_match_decode #(
    parameter int unsigned       WIDTH   = 4,
    parameter logic [WIDTH-1:0] PATTERN = '0
) (
    input  logic [WIDTH-1:0] win_i,
    input  logic             active_i,
    input  logic             qualify_i,
    output logic             match_o
);
    logic [WIDTH-1:0] bit_eq;

    // One equality cell per window bit.
    for (genvar g = 0; g < WIDTH; g++) begin : g_cmp
        assign bit_eq[g] = ~(win_i[g] ^ PATTERN[g]);
    end

    // Combine the cells with the reset and fill qualifiers.
    always_comb begin
        match_o = active_i & qualify_i & (&bit_eq);
    end
endmodule

// File: rtl/pattern_window_detector.sv
// Module: pattern_window_detector (top)
// Serial pattern detector. A shift window feeds a Moore match decode.
// FILL_GATE=1 holds the flag low until WIDTH bits have arrived since reset.
// Assumes: synchronous active-low reset; PRESET differs from PATTERN.
module pattern_window_detector #(
    parameter int unsigned       WIDTH     = pwd_pkg::PWD_WIDTH,
    parameter logic [WIDTH-1:0] PATTERN   = pwd_pkg::PWD_PATTERN,
    parameter logic [WIDTH-1:0] PRESET    = pwd_pkg::PWD_PRESET,
    parameter bit                FILL_GATE = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             din_i,
    output logic [WIDTH-1:0] win_o,
    output logic             match_o
);
    logic qualify;

    pwd_shift_window #(
        .WIDTH  (WIDTH),
        .PRESET (PRESET)
    ) u_window (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .din_i   (din_i),
        .win_o   (win_o)
    );

    // Choose between the fill-qualified and the plain variant.
    if (FILL_GATE) begin : g_fill
        pwd_fill_tracker #(
            .DEPTH (WIDTH)
        ) u_fill (
            .clk_i    (clk_i),
            .rst_n_i  (rst_n_i),
            .filled_o (qualify)
        );
    end else begin : g_nofill
        assign qualify = 1'b1;
    end

    pwd_match_decode #(
        .WIDTH   (WIDTH),
        .PATTERN (PATTERN)
    ) u_decode (
        .win_i     (win_o),
        .active_i  (rst_n_i),
        .qualify_i (qualify),
        .match_o   (match_o)
    );
endmodule

// File: rtl/pwd_checker.sv
// Module: pwd_checker
// Assertion checker bound to every pattern_window_detector instance.
module pwd_checker #(
    parameter int unsigned       WIDTH     = 4,
    parameter logic [WIDTH-1:0] PATTERN   = '0,
    parameter logic [WIDTH-1:0] PRESET    = '1,
    parameter bit                FILL_GATE = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             din,
    input logic [WIDTH-1:0] win,
    input logic             match
);
    localparam bit SELF_SHIFT1 = (PATTERN[WIDTH-2:0] == PATTERN[WIDTH-1:1]);

    // Flag must stay quiet while reset is held.
    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!match); // R1
        end
    end

    AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (win == PRESET)); // R2

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (win == {$past(win[WIDTH-2:0]), $past(din)})); // R3

    AST_HIT_NEEDS_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (win == PATTERN)); // R4

    if (!SELF_SHIFT1) begin : g_adjacent
        AST_NO_ADJACENT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            match |=> !match); // R6
    end

    if (FILL_GATE) begin : g_fill_chk
        localparam int unsigned   CW    = pwd_pkg::pwd_count_bits(WIDTH);
        localparam logic [CW-1:0] LIMIT = CW'(WIDTH);
        logic [CW-1:0] seen_q;

        // Independent count of bits received since reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seen_q <= '0;
            end else if (seen_q != LIMIT) begin
                seen_q <= seen_q + CW'(1);
            end
        end

        AST_FILL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_q != LIMIT) |-> !match); // R7
    end else begin : g_plain_chk
        AST_PLAIN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            (win == PATTERN) |-> match); // R4
    end
endmodule

bind pattern_window_detector pwd_checker #(
    .WIDTH     (WIDTH),
    .PATTERN   (PATTERN),
    .PRESET    (PRESET),
    .FILL_GATE (FILL_GATE)
) u_pwd_checker (
    .clk   (clk_i),
    .rst_n (rst_n_i),
    .din   (din_i),
    .win   (win_o),
    .match (match_o)
);

// File: tb/pattern_window_detector_tb.sv
module pattern_window_detector_tb;
    localparam int         CLK_PERIOD = 10;
    localparam int         W          = 4;
    localparam logic [3:0] PAT        = 4'b1010;
    localparam logic [3:0] PRE        = 4'b1111;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       din   = 1'b0;
    logic [3:0] win_a, win_b;
    logic       match_a, match_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [3:0] mwin = PRE;
    int mfill = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pattern_window_detector u_dut (
        .clk_i (clk), .rst_n_i (rst_n), .din_i (din),
        .win_o (win_a), .match_o (match_a)
    );

    pattern_window_detector #(.FILL_GATE(1'b1)) u_dut_gated (
        .clk_i (clk), .rst_n_i (rst_n), .din_i (din),
        .win_o (win_b), .match_o (match_b)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Hold reset for n edges and check the reset state (R1, R2).
    task automatic do_reset(input int n);
        rst_n = 1'b0;
        din   = 1'b0;
        #1;
        check("R1 flag low in reset", match_a, 0);
        check("R1 gated flag low in reset", match_b, 0);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R1 flag low in reset", match_a, 0);
            check("R1 gated flag low in reset", match_b, 0);
            check("R2 preset loaded", win_a, PRE);
            check("R2 gated preset loaded", win_b, PRE);
        end
        mwin  = PRE;
        mfill = 0;
        rst_n = 1'b1;
    endtask

    // Shift one bit and check window, flag and Moore behaviour (R3, R4, R5, R7).
    task automatic push(input logic b);
        din = b;
        @(posedge clk);
        @(negedge clk);
        mwin = {mwin[2:0], b};
        if (mfill < W) mfill++;
        check("R3 window", win_a, mwin);
        check("R3 gated window", win_b, mwin);
        check("R4 flag", match_a, (mwin == PAT));
        check("R7 gated flag", match_b, ((mwin == PAT) && (mfill >= W)));
        din = ~b;
        #1;
        check("R5 flag ignores input", match_a, (mwin == PAT));
    endtask

    task automatic push_count(input logic [7:0] bits, input int n, output int hits);
        hits = 0;
        for (int i = n - 1; i >= 0; i--) begin
            push(bits[i]);
            if (match_a === 1'b1) hits++;
        end
    endtask

    initial begin
        int hits;
        logic [15:0] lfsr;

        @(negedge clk);
        do_reset(2);

        // R8: timing of the rising and falling edges of the flag.
        push(1'b1); push(1'b0); push(1'b1);
        check("R8 flag low before last bit", match_a, 0);
        push(1'b0);
        check("R8 flag high after last bit", match_a, 1);
        push(1'b0);
        check("R8 flag falls after next edge", match_a, 0);

        // R6: overlapping hits.
        do_reset(1);
        push_count(8'b0010_1010, 6, hits);
        check("R6 two overlapping hits", hits, 2);
        do_reset(1);
        push_count(8'b1010_1010, 8, hits);
        check("R6 three overlapping hits", hits, 3);

        // R7: hit completed by preset bits, plain versus fill-qualified.
        do_reset(1);
        push(1'b0); push(1'b1); push(1'b0);
        check("R7 plain hit using preset", match_a, 1);
        check("R7 gated hit suppressed", match_b, 0);

        // Exhaustive sweep of all 8-bit sequences after reset (R2, R3, R4, R7).
        for (int v = 0; v < 256; v++) begin
            do_reset(1);
            for (int i = 7; i >= 0; i--) push(v[i]);
        end

        // Long pseudo-random stream (R3, R4).
        do_reset(1);
        lfsr = 16'hACE1;
        for (int i = 0; i < 2000; i++) begin
            push(lfsr[0]);
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule